// File: doc/BRIEF.md
# Transmit Character Encoder Front End

This block is the last parallel stage on the transmit side of a serial link before the shifter. It takes one character per clock, marked by a valid strobe. In normal operation the character is an 8-bit value plus a special/data select, and the block turns it into a 10-bit 8B/10B transmission character. It tracks the running disparity across characters so that the line stays DC-balanced. An override bit replaces any character with a deliberately invalid violation symbol. The receiver's error handling can be exercised this way.

Two pins change the mode, and both are active low. The raw pass-through pin sends a 10-bit word straight to the output. This serves systems that code or scramble the stream elsewhere. The self-test pin turns the character source into a 9-bit LFSR. The LFSR then produces a repeating 511-character pseudo-random pattern that a matching LFSR at the far end can predict. The pattern reaches every data code, every defined special code and the violation symbol.

Output bit 0 is sent first. Output bits 0 to 5 carry code bits a, b, c, d, e, i, and bits 6 to 9 carry f, g, h, j. The input byte is read as HGFEDCBA, where bits 4:0 form x (EDCBA) and bits 7:5 form y (HGF).

Top module: `tx_char_encoder`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` of the previous clock in every mode. A cycle without valid advances neither the running disparity nor the self-test sequence.
- R2: With `in_sc_i` low in normal mode, the byte `in_word_i[7:0]` is coded as the standard 8B/10B data character Dx.y for the current running disparity. This includes the alternate y=7 form, which is used after a negative disparity for x = 17, 18, 20 and after a positive disparity for x = 11, 13, 14.
- R3: With `in_sc_i` high in normal mode, twelve byte values are coded as the standard special characters. These are 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE (K28.0 to K28.7, K23.7, K27.7, K29.7, K30.7). Each uses its negative-disparity form, bitwise inverted when the disparity is positive. K28.5 at negative disparity is 0x17C.
- R4: A special request with any other byte value produces the violation symbol.
- R5: In normal mode, `in_word_i[8]` high replaces the character with the violation symbol regardless of the other bits. This symbol has abcdei fghj = 100111 1000 (0x079) at negative disparity and its inverse (0x386) at positive disparity. It is balanced and leaves the disparity unchanged.
- R6: Running disparity is negative after reset. After each coded character it becomes positive if the character has more than five ones, negative if it has fewer than five, and stays the same otherwise. The reset state is `out_valid_o` = 0 and `out_word_o` = 0.
- R7: With `bist_n_i` high and `byp_n_i` low, `in_word_i[9:0]` appears unchanged on the output, and the running disparity is not modified.
- R8: With `bist_n_i` low, input data, select and bypass are ignored. The LFSR is held at 0x1FF while self-test is off. Each valid cycle codes the character with select = NOT s[8] and byte = s[7:0], then steps s to {s[7:0], s[8] XOR s[4]}.
- R9: The self-test sequence repeats every 511 characters and covers all 256 data codes, all twelve special codes and the violation symbol.
- R10: The LFSR never holds the all-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | A character is present this cycle |
| in_sc_i | input | 1 | High: special character; low: data character |
| in_word_i | input | 10 | Bits 7:0 byte, bit 8 violation override, bits 9:0 raw word in bypass |
| byp_n_i | input | 1 | Active-low raw pass-through |
| bist_n_i | input | 1 | Active-low self-test pattern source; takes priority over bypass |
| out_valid_o | output | 1 | Output character valid |
| out_word_o | output | 10 | Transmission character, bit 0 sent first |

## Verification
The bench sweeps every data byte twice and every special byte once while carrying its own disparity model. An encoder that mishandles D.x.7 or D7, or that applies the alternate-form rule at the wrong disparity, therefore miscompares on the following characters as well. The bench sends bypass words and idle cycles between coded characters. A design that lets raw words or gaps touch the disparity or the LFSR then codes the next character with the wrong polarity. The self-test run spans more than two periods, with idle gaps and with garbage on the ignored inputs. Coverage of the violation symbol, K28.5 and 511 distinct characters is checked from the outputs. This catches a wrong tap, a wrong seed, a wrong select mapping or a missing reseed.

// File: rtl/tx_enc_pkg.sv
package tx_enc_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 10;

    // violation symbol, abcdeifghj literal order (a leftmost)
    localparam logic [CODE_W-1:0] VIOL_LIT = 10'b100111_1000;

    typedef enum logic [1:0] {
        MODE_ENC  = 2'd0,
        MODE_RAW  = 2'd1,
        MODE_BIST = 2'd2
    } tx_mode_e;

    typedef struct packed {
        logic              sc;
        logic [BYTE_W-1:0] dat;
    } char_t;

    // literal abcdeifghj -> bus word with a at bit 0
    function automatic logic [CODE_W-1:0] lit_to_bus(input logic [CODE_W-1:0] lit);
        logic [CODE_W-1:0] r;
        for (int i = 0; i < CODE_W; i++) r[i] = lit[CODE_W-1-i];
        return r;
    endfunction

    // 5b/6b sub-block, negative-disparity column, abcdei
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        case (x)
            5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
            5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
            5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
            5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
            5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
            5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
            5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
            5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
            5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
            5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
            5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
            5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
            5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
            5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
            5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
            5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
        endcase
    endfunction

    // 3b/4b sub-block, negative-disparity column, fghj
    function automatic logic [3:0] four_neg(input logic [2:0] y, input logic alt7);
        case (y)
            3'd0: four_neg = 4'b1011;
            3'd1: four_neg = 4'b1001;
            3'd2: four_neg = 4'b0101;
            3'd3: four_neg = 4'b1100;
            3'd4: four_neg = 4'b1101;
            3'd5: four_neg = 4'b1010;
            3'd6: four_neg = 4'b0110;
            default: four_neg = alt7 ? 4'b0111 : 4'b1110;
        endcase
    endfunction

    // special codes, negative-disparity literal; bit 10 = defined
    function automatic logic [CODE_W:0] spec_neg(input logic [BYTE_W-1:0] k);
        case (k)
            8'h1C: spec_neg = {1'b1, 6'b001111, 4'b0100};
            8'h3C: spec_neg = {1'b1, 6'b001111, 4'b1001};
            8'h5C: spec_neg = {1'b1, 6'b001111, 4'b0101};
            8'h7C: spec_neg = {1'b1, 6'b001111, 4'b0011};
            8'h9C: spec_neg = {1'b1, 6'b001111, 4'b0010};
            8'hBC: spec_neg = {1'b1, 6'b001111, 4'b1010};
            8'hDC: spec_neg = {1'b1, 6'b001111, 4'b0110};
            8'hFC: spec_neg = {1'b1, 6'b001111, 4'b1000};
            8'hF7, 8'hFB, 8'hFD, 8'hFE:
                   spec_neg = {1'b1, six_neg(k[4:0]), 4'b1000};
            default: spec_neg = {1'b0, VIOL_LIT};
        endcase
    endfunction

endpackage

// File: rtl/tx_enc_8b10b.sv
module tx_enc_8b10b
    import tx_enc_pkg::*;
(
    input  logic              rd_i,
    input  char_t             ch_i,
    input  logic              viol_i,
    output logic [CODE_W-1:0] code_o,
    output logic              rd_o
);

    logic [4:0]        x;
    logic [2:0]        y;
    logic [5:0]        s6_raw, s6;
    logic [3:0]        s4_raw, s4;
    logic              rd_mid, alt7;
    logic [CODE_W:0]   kent;
    logic [CODE_W-1:0] lit;

    assign x    = ch_i.dat[4:0];
    assign y    = ch_i.dat[7:5];
    assign kent = spec_neg(ch_i.dat);

    // data path: 6b sub-block with disparity correction
    always_comb begin
        s6_raw = six_neg(x);
        s6     = (rd_i && ($countones(s6_raw) != 3 || x == 5'd7)) ? ~s6_raw : s6_raw;
        if ($countones(s6) > 3)      rd_mid = 1'b1;
        else if ($countones(s6) < 3) rd_mid = 1'b0;
        else                         rd_mid = rd_i;
        alt7 = rd_mid ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                      : (x == 5'd17 || x == 5'd18 || x == 5'd20);
        s4_raw = four_neg(y, alt7);
        s4     = (rd_mid && ($countones(s4_raw) != 2 || y == 3'd3)) ? ~s4_raw : s4_raw;
    end

    // source select: override, special, data
    always_comb begin
        if (viol_i || (ch_i.sc && !kent[CODE_W]))
            lit = rd_i ? ~VIOL_LIT : VIOL_LIT;
        else if (ch_i.sc)
            lit = rd_i ? ~kent[CODE_W-1:0] : kent[CODE_W-1:0];
        else
            lit = {s6, s4};
    end

    assign code_o = lit_to_bus(lit);

    always_comb begin
        if ($countones(lit) > 5)      rd_o = 1'b1;
        else if ($countones(lit) < 5) rd_o = 1'b0;
        else                          rd_o = rd_i;
    end

endmodule

// File: rtl/tx_bist_lfsr.sv
module tx_bist_lfsr #(
    parameter int               W    = 9,
    parameter int               TAP  = 5,
    parameter logic [W-1:0]     SEED = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         run_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] s_q;
    logic         fb;

    assign fb = s_q[W-1] ^ s_q[TAP-1];

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) s_q <= SEED;
        else if (step_i)     s_q <= {s_q[W-2:0], fb};
    end

    assign state_o = s_q;

    // R10
    lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        s_q != '0);

    // R1
    lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !step_i) |=> (run_i ? $stable(s_q) : 1'b1));

endmodule

// File: rtl/tx_char_encoder.sv
module tx_char_encoder
    import tx_enc_pkg::*;
#(
    parameter int               LFSR_W    = 9,
    parameter int               LFSR_TAP  = 5,
    parameter logic [LFSR_W-1:0] LFSR_SEED = '1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic              in_sc_i,
    input  logic [CODE_W-1:0] in_word_i,
    input  logic              byp_n_i,
    input  logic              bist_n_i,
    output logic              out_valid_o,
    output logic [CODE_W-1:0] out_word_o
);

    tx_mode_e          mode;
    logic [LFSR_W-1:0] lfsr;
    char_t             ch;
    logic              viol;
    logic [CODE_W-1:0] code;
    logic              rd_next;
    logic              rd_q;
    logic              enc_q;

    always_comb begin
        if (!bist_n_i)     mode = MODE_BIST;
        else if (!byp_n_i) mode = MODE_RAW;
        else               mode = MODE_ENC;
    end

    tx_bist_lfsr #(
        .W    (LFSR_W),
        .TAP  (LFSR_TAP),
        .SEED (LFSR_SEED)
    ) lfsr_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (mode == MODE_BIST),
        .step_i  (in_valid_i && mode == MODE_BIST),
        .state_o (lfsr)
    );

    always_comb begin
        if (mode == MODE_BIST) begin
            ch.sc  = ~lfsr[LFSR_W-1];
            ch.dat = lfsr[BYTE_W-1:0];
            viol   = 1'b0;
        end else begin
            ch.sc  = in_sc_i;
            ch.dat = in_word_i[BYTE_W-1:0];
            viol   = in_word_i[BYTE_W];
        end
    end

    tx_enc_8b10b enc_i (
        .rd_i   (rd_q),
        .ch_i   (ch),
        .viol_i (viol),
        .code_o (code),
        .rd_o   (rd_next)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_valid_o <= 1'b0;
            out_word_o  <= '0;
            rd_q        <= 1'b0;
            enc_q       <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                out_word_o <= (mode == MODE_RAW) ? in_word_i : code;
                enc_q      <= (mode != MODE_RAW);
                if (mode != MODE_RAW) rd_q <= rd_next;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> out_valid_o);

    // R1
    idle_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> !out_valid_o);

    // R6
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (!rd_q && !out_valid_o));

    // R6
    disp_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && enc_q) |->
            ($countones(out_word_o) >= 4 && $countones(out_word_o) <= 6));

    // R7
    raw_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && bist_n_i && !byp_n_i) |=> out_word_o == $past(in_word_i));

    // R7
    raw_rd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && bist_n_i && !byp_n_i) |=> $stable(rd_q));

    // R5
    viol_force_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && bist_n_i && byp_n_i && in_word_i[BYTE_W]) |=>
            (out_word_o == 10'h079 || out_word_o == 10'h386) && $stable(rd_q));

endmodule

// File: tb/tx_char_encoder_tb_top.sv
module tx_char_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sc = 1'b0;
    logic [9:0] in_word = '0;
    logic       byp_n = 1'b1;
    logic       bist_n = 1'b1;
    logic       out_valid;
    logic [9:0] out_word;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic rd_m = 1'b0;

    always #10 clk = ~clk;

    tx_char_encoder dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .in_valid_i  (in_valid),
        .in_sc_i     (in_sc),
        .in_word_i   (in_word),
        .byp_n_i     (byp_n),
        .bist_n_i    (bist_n),
        .out_valid_o (out_valid),
        .out_word_o  (out_word)
    );

    // 6b columns {negative, positive}, abcdei
    function automatic logic [11:0] d6(input int x);
        case (x)
            0: d6 = {6'b100111, 6'b011000};   1: d6 = {6'b011101, 6'b100010};
            2: d6 = {6'b101101, 6'b010010};   3: d6 = {6'b110001, 6'b110001};
            4: d6 = {6'b110101, 6'b001010};   5: d6 = {6'b101001, 6'b101001};
            6: d6 = {6'b011001, 6'b011001};   7: d6 = {6'b111000, 6'b000111};
            8: d6 = {6'b111001, 6'b000110};   9: d6 = {6'b100101, 6'b100101};
            10: d6 = {6'b010101, 6'b010101};  11: d6 = {6'b110100, 6'b110100};
            12: d6 = {6'b001101, 6'b001101};  13: d6 = {6'b101100, 6'b101100};
            14: d6 = {6'b011100, 6'b011100};  15: d6 = {6'b010111, 6'b101000};
            16: d6 = {6'b011011, 6'b100100};  17: d6 = {6'b100011, 6'b100011};
            18: d6 = {6'b010011, 6'b010011};  19: d6 = {6'b110010, 6'b110010};
            20: d6 = {6'b001011, 6'b001011};  21: d6 = {6'b101010, 6'b101010};
            22: d6 = {6'b011010, 6'b011010};  23: d6 = {6'b111010, 6'b000101};
            24: d6 = {6'b110011, 6'b001100};  25: d6 = {6'b100110, 6'b100110};
            26: d6 = {6'b010110, 6'b010110};  27: d6 = {6'b110110, 6'b001001};
            28: d6 = {6'b001110, 6'b001110};  29: d6 = {6'b101110, 6'b010001};
            30: d6 = {6'b011110, 6'b100001};  default: d6 = {6'b101011, 6'b010100};
        endcase
    endfunction

    // 4b columns {negative, positive}, fghj; y=8 denotes alternate 7
    function automatic logic [7:0] d4(input int y);
        case (y)
            0: d4 = {4'b1011, 4'b0100};  1: d4 = {4'b1001, 4'b1001};
            2: d4 = {4'b0101, 4'b0101};  3: d4 = {4'b1100, 4'b0011};
            4: d4 = {4'b1101, 4'b0010};  5: d4 = {4'b1010, 4'b1010};
            6: d4 = {4'b0110, 4'b0110};  7: d4 = {4'b1110, 4'b0001};
            default: d4 = {4'b0111, 4'b1000};
        endcase
    endfunction

    function automatic logic [10:0] kref(input logic [7:0] k);
        logic [3:0] k28f [8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011,
                                 4'b0010, 4'b1010, 4'b0110, 4'b1000};
        if (k[4:0] == 5'd28) return {1'b1, 6'b001111, k28f[k[7:5]]};
        if (k == 8'hF7 || k == 8'hFB || k == 8'hFD || k == 8'hFE)
            return {1'b1, d6(int'(k[4:0]))[11:6], 4'b1000};
        return 11'd0;
    endfunction

    function automatic logic [9:0] flip10(input logic [9:0] l);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = l[9-i];
        return r;
    endfunction

    // returns {next disparity, bus word}
    function automatic logic [10:0] mdl(input logic rd, input logic sc,
                                        input logic [7:0] b, input logic ovr);
        logic [9:0]  lit;
        logic [10:0] k;
        logic [5:0]  s6;
        logic [3:0]  s4;
        logic        r;
        int          x, y;
        x = int'(b[4:0]);
        y = int'(b[7:5]);
        k = kref(b);
        if (ovr || (sc && !k[10])) begin
            lit = rd ? ~10'b1001111000 : 10'b1001111000;
            r   = rd;
        end else if (sc) begin
            lit = rd ? ~k[9:0] : k[9:0];
            r   = ($countones(lit) > 5) ? 1'b1 : ($countones(lit) < 5) ? 1'b0 : rd;
        end else begin
            s6 = rd ? d6(x)[5:0] : d6(x)[11:6];
            r  = ($countones(s6) > 3) ? 1'b1 : ($countones(s6) < 3) ? 1'b0 : rd;
            if (y == 7 && ((!r && (x == 17 || x == 18 || x == 20)) ||
                           (r && (x == 11 || x == 13 || x == 14))))
                y = 8;
            s4 = r ? d4(y)[3:0] : d4(y)[7:4];
            r  = ($countones(s4) > 2) ? 1'b1 : ($countones(s4) < 2) ? 1'b0 : r;
            lit = {s6, s4};
        end
        return {r, flip10(lit)};
    endfunction

    task automatic cyc(input logic v, input logic sc, input logic [9:0] w,
                       input logic bp, input logic bs);
        in_valid = v; in_sc = sc; in_word = w; byp_n = bp; bist_n = bs;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic v_exp, input logic [9:0] w_exp);
        n_vec++;
        if (out_valid !== v_exp || (v_exp && out_word !== w_exp)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b word=%03h expected valid=%0b word=%03h",
                     tag, out_valid, out_word, v_exp, w_exp);
        end
    endtask

    task automatic enc(input string tag, input logic sc, input logic [8:0] b);
        logic [10:0] e;
        e = mdl(rd_m, sc, b[7:0], b[8]);
        cyc(1'b1, sc, {1'b0, b}, 1'b1, 1'b1);
        rd_m = e[10];
        chk(tag, 1'b1, e[9:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: valid=%0b word=%03h expected valid=1 word=000",
                     out_valid, out_word);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [8:0]  lf;
        logic [10:0] e;
        bit          seen [512];
        int          distinct, ndata, nviol, nk285;

        repeat (3) @(negedge clk);
        chk("R6 reset", 1'b0, 10'h000);
        rst = 1'b0;

        // R3: known special at negative disparity
        cyc(1'b1, 1'b1, 10'h0BC, 1'b1, 1'b1);
        chk("R3 K28.5", 1'b1, 10'h17C);
        rd_m = 1'b1;

        // R2 R6: all data bytes, two passes
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 256; i++) enc("R2", 1'b0, {1'b0, 8'(i)});

        // R3 R4: every special request
        for (int i = 0; i < 256; i++) enc(kref(8'(i))[10] ? "R3" : "R4", 1'b1, {1'b0, 8'(i)});

        // R5: override bit
        for (int i = 0; i < 16; i++) begin
            enc("R5", i[0], {1'b1, 8'(i * 17)});
            enc("R5 follow", 1'b0, {1'b0, 8'(i * 5)});
        end

        // R1: idle gap leaves state alone
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 10'h3FF, 1'b1, 1'b1);
            chk("R1 idle", 1'b0, 10'h000);
        end
        enc("R1 after idle", 1'b0, 9'h000);

        // R7: raw words, then disparity untouched
        for (int i = 0; i < 1024; i++) begin
            cyc(1'b1, i[1], 10'(i), 1'b0, 1'b1);
            chk("R7", 1'b1, 10'(i));
            if (i % 128 == 127) enc("R7 rd kept", 1'b0, 9'h003);
        end

        // R8 R9 R10: self-test pattern
        lf = 9'h1FF;
        distinct = 0; ndata = 0; nviol = 0; nk285 = 0;
        for (int i = 0; i < 1100; i++) begin
            if (i % 97 == 50) begin
                cyc(1'b0, 1'b1, 10'h155, 1'b0, 1'b0);
                chk("R1 bist idle", 1'b0, 10'h000);
            end
            e = mdl(rd_m, ~lf[8], lf[7:0], 1'b0);
            cyc(1'b1, i[0], 10'(i * 37), i[1], 1'b0);
            rd_m = e[10];
            chk("R8", 1'b1, e[9:0]);
            if (i < 511) begin
                if (!seen[{~lf[8], lf[7:0]}]) begin
                    distinct++;
                    if (lf[8]) ndata++;
                end
                seen[{~lf[8], lf[7:0]}] = 1'b1;
            end
            if (out_word == 10'h079 || out_word == 10'h386) nviol++;
            if (out_word == 10'h17C || out_word == 10'h283) nk285++;
            lf = {lf[7:0], lf[8] ^ lf[4]};
            if (i == 510) begin
                n_vec++;
                if (lf != 9'h1FF) begin
                    n_bad++;
                    $display("FAIL R9 period: state=%03h expected=%03h", lf, 9'h1FF);
                end
            end
        end
        n_vec++;
        if (distinct != 511 || ndata != 256) begin
            n_bad++;
            $display("FAIL R10 coverage: distinct=%0d data=%0d expected distinct=511 data=256",
                     distinct, ndata);
        end
        n_vec++;
        if (nviol == 0 || nk285 == 0) begin
            n_bad++;
            $display("FAIL R9 codes: viol=%0d k285=%0d expected both nonzero", nviol, nk285);
        end

        // R8: leaving self-test reseeds
        cyc(1'b1, 1'b0, 10'h000, 1'b1, 1'b1);
        e = mdl(rd_m, 1'b0, 8'h00, 1'b0);
        rd_m = e[10];
        chk("R2 between", 1'b1, e[9:0]);
        e = mdl(rd_m, 1'b0, 8'hFF, 1'b0);
        cyc(1'b1, 1'b0, 10'h000, 1'b1, 1'b0);
        rd_m = e[10];
        chk("R8 reseed", 1'b1, e[9:0]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule